// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a banked on-chip scratchpad. It serves one vector request at a time, which carries a byte address and a valid bit for each of 32 lanes. An optional 128-byte XOR swizzle can remap each address before the bank is picked. The block then finds every bank that several lanes want to read at different words. It splits the request into as many back-to-back passes as the worst such bank needs. On each pass every bank reads at most one word. Lanes that name the same word share that one read.

Each pass comes back as a single-cycle response. The response carries a mask of the lanes finished in that pass, their data, a mask of the banks that were read, and a flag that marks the final pass. The request side is a valid/ready stream. `req_ready` is high only while the block is idle, so a producer holds its request (valid, lanes, addresses and swizzle select) until a cycle in which ready is high. A request offered while the block is busy is not taken. The response side has no back-pressure: the consumer must take each pass in the cycle it appears. The storage is a behavioural array that is loaded with a fixed pattern at reset and is only read.

Top module: `scratch_bank_arb`

## Requirements
- R1: After any swizzle, byte address bits [6:2] give the bank and bits [10:7] give the row. Bank b, row r holds ((r*32+b) * 0x00010003) XOR 0xA5C30000. Each served lane returns that word in its 32-bit slice of `rsp_data` (lane l at bits [32l+31:32l]), and lanes not served in a pass read zero.
- R2: With `swz_en` high at acceptance, address bits [6:4] are replaced by bits[6:4] XOR bits[9:7]; with it low the address is used unchanged. Eight lanes at addresses 0,128,...,896 take 8 passes unswizzled and 1 pass swizzled.
- R3: A request with at least one valid lane yields exactly one response per pass, on consecutive cycles, the first one registered at the clock edge after acceptance. The number of passes equals the largest count of distinct rows wanted in any one bank, and no response follows the last pass.
- R4: Lanes that name the same word (same bank and row) finish in the same pass and add no pass.
- R5: On each pass every bank serves the word of its lowest-numbered pending lane, together with every pending lane that names that same word.
- R6: Lanes whose valid bit is low are ignored. They never appear in a done mask and never cause a pass.
- R7: A request with no valid lanes yields a single response at the accepting edge, with `rsp_last` high, an empty done mask, no bank read, and the block stays ready.
- R8: `req_ready` is low from the edge that accepts a request with valid lanes until the edge that registers its last pass. A request offered during that time is not accepted.
- R9: `rsp_bank_act` marks exactly the banks read in that pass, which are the banks of the lanes in that pass's done mask.
- R10: `rsp_last` is high only on the final pass. The done masks of one request are disjoint, and together they equal its valid mask.
- R11: During and right after reset, `req_ready` is high and `rsp_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_lane_vld | input | LANES | Per-lane valid bits |
| req_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane l at [l*ADDR_W +: ADDR_W] |
| swz_en | input | 1 | Apply the 128-byte swizzle to this request |
| rsp_valid | output | 1 | One pass result present this cycle |
| rsp_lane_done | output | LANES | Lanes finished in this pass |
| rsp_data | output | LANES*32 | Per-lane read data, zero for lanes not served |
| rsp_bank_act | output | BANKS | Banks read in this pass |
| rsp_last | output | 1 | Final pass of the request |
| busy | output | 1 | Passes outstanding |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32 banks and 16 rows per bank, which gives 11-bit byte addresses. Bits [9:7] then lie inside the address, so the swizzle can change bank selection. With 16 rows, a single bank can see up to 16 distinct words, so requests with anything from one to sixteen passes can occur. Mixing random requests over a narrow set of rows with random requests over all rows covers broadcast sharing, deep conflicts and sparse valid masks together.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Reset-time content of a storage word, keyed by its word index row*BANKS+bank
  function automatic word_t fill_word(input logic [31:0] idx);
    return (idx * 32'h0001_0003) ^ 32'hA5C3_0000;
  endfunction
endpackage

// File: rtl/sba_swizzle.sv
module sba_swizzle #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 11
) (
  input  logic                      swz_en,
  input  logic [LANES*ADDR_W-1:0]   addr_in,
  output logic [LANES*(ADDR_W-2)-1:0] waddr_out
);
  localparam int WA_W = ADDR_W - 2;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] m;
    logic              unused_lsb;
    assign a = addr_in[l*ADDR_W +: ADDR_W];
    always_comb begin
      m = a;
      if (swz_en) m[6:4] = a[6:4] ^ a[9:7];
    end
    assign waddr_out[l*WA_W +: WA_W] = m[ADDR_W-1:2];
    assign unused_lsb = ^m[1:0];
  end
endmodule

// File: rtl/sba_conflict.sv
module sba_conflict #(
  parameter int LANES    = 32,
  parameter int BANKS    = 32,
  parameter int ROW_BITS = 4,
  localparam int BANK_BITS = $clog2(BANKS),
  localparam int WA_W      = ROW_BITS + BANK_BITS
) (
  input  logic [LANES-1:0]          pend,
  input  logic [LANES*WA_W-1:0]     waddr,
  output logic [LANES-1:0]          served,
  output logic [BANKS-1:0]          bank_act,
  output logic [BANKS*ROW_BITS-1:0] bank_row
);
  logic [BANK_BITS-1:0] lb [LANES];
  logic [ROW_BITS-1:0]  lr [LANES];
  logic [ROW_BITS-1:0]  brow [BANKS];

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lb[l] = waddr[l*WA_W +: BANK_BITS];
    assign lr[l] = waddr[l*WA_W + BANK_BITS +: ROW_BITS];
  end

  // Per bank: the lowest-numbered pending lane picks the row (scan high to low, last hit wins)
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_comb begin
      bank_act[b] = 1'b0;
      brow[b]     = '0;
      for (int l = LANES-1; l >= 0; l--) begin
        if (pend[l] && lb[l] == BANK_BITS'(b)) begin
          bank_act[b] = 1'b1;
          brow[b]     = lr[l];
        end
      end
    end
    assign bank_row[b*ROW_BITS +: ROW_BITS] = brow[b];
  end

  // A lane finishes when its bank's chosen row is its own row (broadcast share)
  for (genvar l = 0; l < LANES; l++) begin : g_serve
    assign served[l] = pend[l] && bank_act[lb[l]] && (brow[lb[l]] == lr[l]);
  end
endmodule

// File: rtl/sba_bank_array.sv
module sba_bank_array import sba_pkg::*; #(
  parameter int BANKS    = 32,
  parameter int ROW_BITS = 4,
  localparam int ROWS    = 1 << ROW_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BANKS*ROW_BITS-1:0] rd_row,
  output logic [BANKS*WORD_W-1:0]   rd_data
);
  word_t mem [BANKS][ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < ROWS; r++)
          mem[b][r] <= fill_word(32'(r*BANKS + b));
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_rd
    assign rd_data[b*WORD_W +: WORD_W] = mem[b][rd_row[b*ROW_BITS +: ROW_BITS]];
  end
endmodule

// File: rtl/scratch_bank_arb.sv
module scratch_bank_arb import sba_pkg::*; #(
  parameter int LANES    = 32,
  parameter int BANKS    = 32,
  parameter int ROW_BITS = 4,
  localparam int BANK_BITS = $clog2(BANKS),
  localparam int ADDR_W    = ROW_BITS + BANK_BITS + 2,
  localparam int WA_W      = ADDR_W - 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [LANES-1:0]         req_lane_vld,
  input  logic [LANES*ADDR_W-1:0]  req_addr,
  input  logic                     swz_en,
  output logic                     rsp_valid,
  output logic [LANES-1:0]         rsp_lane_done,
  output logic [LANES*WORD_W-1:0]  rsp_data,
  output logic [BANKS-1:0]         rsp_bank_act,
  output logic                     rsp_last,
  output logic                     busy
);
  logic [LANES*WA_W-1:0]     swz_waddr;
  logic [LANES*WA_W-1:0]     waddr_q;
  logic [LANES-1:0]          pend_q, served, pend_next;
  logic [BANKS-1:0]          bank_act;
  logic [BANKS*ROW_BITS-1:0] bank_row;
  logic [BANKS*WORD_W-1:0]   bank_data;
  logic [LANES*WORD_W-1:0]   lane_data;
  logic                      busy_q;

  sba_swizzle #(.LANES(LANES), .ADDR_W(ADDR_W)) u_swz (
    .swz_en(swz_en), .addr_in(req_addr), .waddr_out(swz_waddr));

  sba_conflict #(.LANES(LANES), .BANKS(BANKS), .ROW_BITS(ROW_BITS)) u_cfl (
    .pend(pend_q), .waddr(waddr_q), .served(served),
    .bank_act(bank_act), .bank_row(bank_row));

  sba_bank_array #(.BANKS(BANKS), .ROW_BITS(ROW_BITS)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_row(bank_row), .rd_data(bank_data));

  // Route each bank's word to the lanes it served
  for (genvar l = 0; l < LANES; l++) begin : g_route
    logic [BANK_BITS-1:0] bsel;
    assign bsel = waddr_q[l*WA_W +: BANK_BITS];
    assign lane_data[l*WORD_W +: WORD_W] =
      served[l] ? bank_data[WORD_W*int'(bsel) +: WORD_W] : '0;
  end

  assign pend_next = pend_q & ~served;
  assign req_ready = !busy_q;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      pend_q        <= '0;
      waddr_q       <= '0;
      rsp_valid     <= 1'b0;
      rsp_last      <= 1'b0;
      rsp_lane_done <= '0;
      rsp_bank_act  <= '0;
      rsp_data      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          if (|req_lane_vld) begin
            busy_q  <= 1'b1;
            pend_q  <= req_lane_vld;
            waddr_q <= swz_waddr;
          end else begin
            // Empty request: finish at once, no bank touched
            rsp_valid     <= 1'b1;
            rsp_last      <= 1'b1;
            rsp_lane_done <= '0;
            rsp_bank_act  <= '0;
            rsp_data      <= '0;
          end
        end
      end else begin
        rsp_valid     <= 1'b1;
        rsp_lane_done <= served;
        rsp_bank_act  <= bank_act;
        rsp_data      <= lane_data;
        rsp_last      <= ~|pend_next;
        pend_q        <= pend_next;
        busy_q        <= |pend_next;
      end
    end
  end
endmodule

// File: rtl/sba_chk.sv
module sba_chk #(
  parameter int LANES = 32,
  parameter int BANKS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_lane_vld,
  input logic             rsp_valid,
  input logic [LANES-1:0] rsp_lane_done,
  input logic [BANKS-1:0] rsp_bank_act,
  input logic             rsp_last,
  input logic             busy
);
  logic [LANES-1:0] acc_mask, seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_mask <= '0;
      seen     <= '0;
    end else if (req_valid && req_ready) begin
      acc_mask <= req_lane_vld;
      seen     <= '0;
    end else if (rsp_valid) begin
      seen <= seen | rsp_lane_done;
    end
  end

  assert_empty_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_lane_done == '0) |-> (rsp_bank_act == '0 && rsp_last));

  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_pass_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rsp_valid);

  assert_no_stray_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_valid && req_ready)) |=> !rsp_valid);

  assert_act_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_bank_act) <= $countones(rsp_lane_done)));

  assert_done_in_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_lane_done & ~acc_mask) == '0));

  assert_done_disjoint_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_lane_done & seen) == '0));

  assert_last_complete_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |-> (((seen | rsp_lane_done) == acc_mask) && !busy));
endmodule

bind scratch_bank_arb sba_chk #(.LANES(LANES), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_lane_vld(req_lane_vld), .rsp_valid(rsp_valid), .rsp_lane_done(rsp_lane_done),
  .rsp_bank_act(rsp_bank_act), .rsp_last(rsp_last), .busy(busy));

// File: tb/scratch_bank_arb_bench.sv
module scratch_bank_arb_bench;
  localparam int LANES = 32, BANKS = 32, ROW_BITS = 4, ADDR_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, swz_en = 1'b0;
  logic req_ready, rsp_valid, rsp_last, busy;
  logic [LANES-1:0] req_lane_vld = '0, rsp_lane_done;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES*32-1:0] rsp_data;
  logic [BANKS-1:0] rsp_bank_act;

  int n_tests = 0, n_fail = 0;
  logic [ADDR_W-1:0] t_addr [LANES];
  int last_passes;

  always #5 clk = ~clk;

  scratch_bank_arb u_scratch_bank_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lane_vld(req_lane_vld), .req_addr(req_addr), .swz_en(swz_en),
    .rsp_valid(rsp_valid), .rsp_lane_done(rsp_lane_done), .rsp_data(rsp_data),
    .rsp_bank_act(rsp_bank_act), .rsp_last(rsp_last), .busy(busy));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] phys(input logic [ADDR_W-1:0] a, input bit s);
    logic [ADDR_W-1:0] r;
    r = a;
    if (s) r[6:4] = a[6:4] ^ a[9:7];
    return r;
  endfunction

  function automatic logic [31:0] exp_word(input logic [4:0] b, input logic [3:0] r);
    logic [31:0] w;
    w = 32'(r) * 32 + 32'(b);
    return (w * 32'h0001_0003) ^ 32'hA5C3_0000;
  endfunction

  // One request: drive, then check every pass against the bench model
  task automatic run_req(input logic [31:0] vld, input bit s, input bit hold);
    logic [4:0] pb [LANES];
    logic [3:0] pr [LANES];
    logic [31:0] pend, served;
    logic [BANKS-1:0] act;
    logic [3:0] lrow [BANKS];
    int passes;
    for (int l = 0; l < LANES; l++) begin
      logic [ADDR_W-1:0] p;
      p = phys(t_addr[l], s);
      pb[l] = p[6:2];
      pr[l] = p[10:7];
    end
    @(negedge clk);
    for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = t_addr[l];
    req_lane_vld = vld; swz_en = s; req_valid = 1'b1;
    chk("R8 ready when idle", 64'(req_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    if (vld == 0) begin
      req_valid = 1'b0;
      chk("R7 empty rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R7 empty last", 64'(rsp_last), 64'd1);
      chk("R7 empty mask", 64'(rsp_lane_done), 64'd0);
      chk("R7 empty bank act", 64'(rsp_bank_act), 64'd0);
      chk("R7 empty stays ready", 64'(req_ready), 64'd1);
      last_passes = 1;
      return;
    end
    if (hold) begin
      // Competing request held during the passes: must not be taken
      for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(l*128);
      req_lane_vld = '1; swz_en = 1'b0;
    end else req_valid = 1'b0;
    chk("R3 no rsp at accept edge", 64'(rsp_valid), 64'd0);
    chk("R8 ready low after accept", 64'(req_ready), 64'd0);
    pend = vld; passes = 0;
    while (pend != 0 && passes < 40) begin
      @(posedge clk); @(negedge clk);
      passes++;
      act = '0;
      for (int b = 0; b < BANKS; b++) lrow[b] = '0;
      for (int l = 0; l < LANES; l++)
        if (pend[l] && !act[pb[l]]) begin act[pb[l]] = 1'b1; lrow[pb[l]] = pr[l]; end
      served = '0;
      for (int l = 0; l < LANES; l++)
        if (pend[l] && lrow[pb[l]] == pr[l]) served[l] = 1'b1;
      pend = pend & ~served;
      chk("R3 pass rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R5 pass done mask", 64'(rsp_lane_done), 64'(served));
      chk("R9 bank act", 64'(rsp_bank_act), 64'(act));
      chk("R10 last flag", 64'(rsp_last), 64'(pend == 0));
      chk("R8 ready vs drain", 64'(req_ready), 64'(pend == 0));
      for (int l = 0; l < LANES; l++)
        chk("R1 lane data", 64'(rsp_data[l*32 +: 32]),
            served[l] ? 64'(exp_word(pb[l], pr[l])) : 64'd0);
    end
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R3 no extra pass", 64'(rsp_valid), 64'd0);
    chk("R8 held request not taken", 64'(busy), 64'd0);
    last_passes = passes;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    chk("R11 reset ready", 64'(req_ready), 64'd1);
    chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 reset busy", 64'(busy), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset busy", 64'(busy), 64'd0);

    // R1: linear, one lane per bank
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(l*4 + 256);
    run_req('1, 1'b0, 1'b0);
    chk("R1 linear one pass", 64'(last_passes), 64'd1);

    // R4: every lane the same word
    for (int l = 0; l < LANES; l++) t_addr[l] = 11'h2C4;
    run_req('1, 1'b0, 1'b0);
    chk("R4 broadcast one pass", 64'(last_passes), 64'd1);

    // R2: column walk, rows of 128 bytes
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'((l % 8) * 128);
    run_req(32'h0000_00FF, 1'b0, 1'b0);
    chk("R2 column walk unswizzled", 64'(last_passes), 64'd8);
    run_req(32'h0000_00FF, 1'b1, 1'b0);
    chk("R2 column walk swizzled", 64'(last_passes), 64'd1);

    // R7: no valid lanes
    run_req('0, 1'b0, 1'b0);

    // R6: invalid lanes would conflict but must be ignored
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(l*128);
    t_addr[3] = 11'h00C;
    run_req(32'h0000_0009, 1'b0, 1'b0);
    chk("R6 invalid lanes ignored", 64'(last_passes), 64'd1);

    // R5: lane 2 row 1, lane 5 row 3, lane 9 shares lane 5 word, all bank 4
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(l*4);
    t_addr[2] = 11'h090; t_addr[5] = 11'h190; t_addr[9] = 11'h190;
    run_req(32'h0000_0224, 1'b0, 1'b0);
    chk("R5 priority two passes", 64'(last_passes), 64'd2);

    // R8: request held during a 4-pass drain
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'((l % 4) * 128 + 8);
    run_req('1, 1'b0, 1'b1);
    chk("R8 held drain passes", 64'(last_passes), 64'd4);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int mode;
      logic [31:0] v;
      mode = $urandom % 4;
      for (int l = 0; l < LANES; l++) begin
        case (mode)
          0: t_addr[l] = ADDR_W'($urandom);
          1: t_addr[l] = ADDR_W'(($urandom % 2) * 128 + ($urandom % 32) * 4);
          2: t_addr[l] = ADDR_W'(l * (1 + (i % 9)) * 4);
          default: t_addr[l] = ADDR_W'(($urandom % 4) * 128 + ($urandom % 4) * 16);
        endcase
      end
      v = (mode == 3) ? ($urandom & $urandom) : $urandom;
      if (i % 37 == 0) v = '0;
      run_req(v, 1'($urandom), 1'(i % 5 == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule